// File: doc/BRIEF.md
# Open-Row DRAM Bank Timing Controller

This block stands in for one DRAM bank of 4096 rows, each 4096 bits wide, with a single row buffer in front of it. A host hands it one read at a time over a valid/ready handshake. The 24-bit address holds the row in its upper twelve bits and the column in its lower twelve. The block compares the requested row with the row already held in the buffer and puts the access into one of three classes: a hit on the open row, an access to an empty buffer, or a conflict with another open row. Each class has its own latency, given in clock cycles by a parameter.

The controller drives a command strobe sequence: a writeback strobe that returns the old row (conflict only), a row strobe carrying the new row (empty and conflict), and a column strobe carrying the column. It then shifts out an eight-bit group of the open row, one bit per cycle, together with the access class. The page policy is open: the row stays in the buffer after each access, so the next access to the same row hits.

The cell array has no write path. Its contents are a fixed pattern computed from the address, so every data bit can be predicted.

Top module: `openrow_bank_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, `req_ready` is 1 and every strobe, `dout_valid`, `dout_bit` and `acc_class` are 0. Reset empties the row buffer, so the first request after any reset is classified as empty.
- R2: The row address is `req_addr[23:12]` and the column address is `req_addr[11:0]`. At most one of `cmd_wb`, `cmd_ras` and `cmd_cas` is high in a cycle. `cmd_row` carries a row only when `cmd_wb` or `cmd_ras` is high, and `cmd_col` carries the column only when `cmd_cas` is high. Both buses are 0 at all other times.
- R3: The class code is 2'b10 (empty) when no row is open, 2'b01 (hit) when the open row equals the requested row, and 2'b11 (conflict) otherwise.
- R4: The edge that accepts a request is edge 0, and "cycle n" is the time between edge n-1 and edge n. A hit raises `cmd_cas` in cycle L_HIT-1 (default 1). It issues no row strobe and no writeback strobe.
- R5: An empty access raises `cmd_ras` with the new row in cycle 1 and `cmd_cas` in cycle L_EMPTY-1 (default 3).
- R6: A conflict raises `cmd_wb` with the previously open row in cycle 1. It raises `cmd_ras` with the new row in cycle L_CONF-L_EMPTY+L_HIT-1 (default 3) and `cmd_cas` in cycle L_CONF-1 (default 5).
- R7: Data bit k (k = 0..7) is on `dout_bit`, with `dout_valid` high, in cycle L+k, where L is the latency of the class. The byte sent is (row + column[11:3]) mod 256, least significant bit first. `dout_bit` is 0 whenever `dout_valid` is low.
- R8: `req_ready` falls in cycle 1, stays low through cycle L+7, and is high again in cycle L+8. A request held valid while ready is low is taken only at the first edge at which ready is high.
- R9: `acc_class` shows the class code in every data cycle and is 2'b00 whenever `dout_valid` is low.
- R10: After an access the row stays open. A later request to the same row at any column is a hit, even after gaps with no requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 24 | Row (upper 12 bits) and column (lower 12 bits) |
| cmd_ras | output | 1 | Row strobe, opens `cmd_row` |
| cmd_cas | output | 1 | Column strobe, selects `cmd_col` |
| cmd_wb | output | 1 | Writeback strobe, returns `cmd_row` to the array |
| cmd_row | output | 12 | Row address for the row or writeback strobe |
| cmd_col | output | 12 | Column address for the column strobe |
| dout_valid | output | 1 | Serial data bit present |
| dout_bit | output | 1 | Serial data, least significant bit first |
| acc_class | output | 2 | Access class: 01 hit, 10 empty, 11 conflict, 00 idle |

## Verification
The assertions assume that reset is applied before the first request. They also assume `req_valid` and `req_addr` are known whenever the host offers a request, because the expected class is captured from the row bits at the accepting edge. The bench drives every input at the falling edge, so it always applies a defined address. It raises valid only together with an address, and it sometimes holds valid high through a busy burst. That exercises the rule that a request is taken at the first ready edge.

// File: rtl/openrow_bank_pkg.sv
package openrow_bank_pkg;

   // Access class codes seen on the class output
   typedef enum logic [1:0] {
      ACC_NONE     = 2'b00,
      ACC_HIT      = 2'b01,
      ACC_EMPTY    = 2'b10,
      ACC_CONFLICT = 2'b11
   } acc_class_e;

endpackage

// File: rtl/bank_row_classifier.sv
module bank_row_classifier
   import openrow_bank_pkg::*;
#(
   parameter int ROW_W   = 12,
   parameter int CNT_W   = 5,
   parameter int L_HIT   = 2,
   parameter int L_EMPTY = 4,
   parameter int L_CONF  = 6
) (
   input  logic             open_vld,
   input  logic [ROW_W-1:0] open_row,
   input  logic [ROW_W-1:0] req_row,
   output acc_class_e       cls,
   output logic [CNT_W-1:0] lat
);

   localparam logic [CNT_W-1:0] LAT_H = CNT_W'(L_HIT);
   localparam logic [CNT_W-1:0] LAT_E = CNT_W'(L_EMPTY);
   localparam logic [CNT_W-1:0] LAT_C = CNT_W'(L_CONF);

   always_comb begin
      if (!open_vld) begin
         cls = ACC_EMPTY;
         lat = LAT_E;
      end else if (open_row == req_row) begin
         cls = ACC_HIT;
         lat = LAT_H;
      end else begin
         cls = ACC_CONFLICT;
         lat = LAT_C;
      end
   end

endmodule

// File: rtl/bank_sequencer.sv
module bank_sequencer
   import openrow_bank_pkg::*;
#(
   parameter int CNT_W   = 5,
   parameter int BURST   = 8,
   parameter int L_HIT   = 2,
   parameter int L_EMPTY = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             accept,
   input  acc_class_e       cls_in,
   input  logic [CNT_W-1:0] lat_in,
   output logic             busy,
   output acc_class_e       cls,
   output logic             ras,
   output logic             cas,
   output logic             wb,
   output logic             dvalid
);

   // Row strobe leads the column strobe by the empty-minus-hit gap
   localparam logic [CNT_W-1:0] ACT_LEAD   = CNT_W'(L_EMPTY - L_HIT + 1);
   localparam logic [CNT_W-1:0] CAS_LEAD   = CNT_W'(1);
   localparam logic [CNT_W-1:0] BURST_TAIL = CNT_W'(BURST - 1);
   localparam logic [CNT_W-1:0] WB_AT      = CNT_W'(1);

   logic [CNT_W-1:0] cyc_q;
   logic [CNT_W-1:0] lat_q;
   logic             last;

   assign last = busy && (cyc_q == lat_q + BURST_TAIL);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy  <= 1'b0;
         cyc_q <= '0;
         lat_q <= '0;
         cls   <= ACC_NONE;
      end else if (accept) begin
         busy  <= 1'b1;
         cyc_q <= CNT_W'(1);
         lat_q <= lat_in;
         cls   <= cls_in;
      end else if (last) begin
         busy  <= 1'b0;
         cyc_q <= '0;
      end else if (busy) begin
         cyc_q <= cyc_q + CNT_W'(1);
      end
   end

   always_comb begin
      wb     = busy && (cls == ACC_CONFLICT) && (cyc_q == WB_AT);
      ras    = busy && (cls != ACC_HIT) && (cyc_q == lat_q - ACT_LEAD);
      cas    = busy && (cyc_q == lat_q - CAS_LEAD);
      dvalid = busy && (cyc_q >= lat_q);
   end

endmodule

// File: rtl/bank_row_store.sv
module bank_row_store #(
   parameter int ROW_W = 12,
   parameter int COL_W = 12,
   parameter int BURST = 8
) (
   input  logic                                clk,
   input  logic                                rst,
   input  logic                                activate,
   input  logic                                close,
   input  logic [ROW_W-1:0]                    act_row,
   input  logic [COL_W-$clog2(BURST)-1:0]      grp_sel,
   output logic                                open_vld,
   output logic [ROW_W-1:0]                    open_row,
   output logic [BURST-1:0]                    grp_bits
);

   localparam int ROW_BITS = 1 << COL_W;
   localparam int GROUPS   = ROW_BITS / BURST;

   logic [ROW_BITS-1:0] fill;
   logic [ROW_BITS-1:0] page_q;

   // Fixed cell pattern: each aligned group holds row plus group index
   for (genvar g = 0; g < GROUPS; g++) begin : g_fill
      assign fill[g*BURST +: BURST] = BURST'(act_row) + BURST'(g);
   end

   always_ff @(posedge clk) begin
      if (activate) begin
         page_q <= fill;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         open_vld <= 1'b0;
         open_row <= '0;
      end else if (activate) begin
         open_vld <= 1'b1;
         open_row <= act_row;
      end else if (close) begin
         open_vld <= 1'b0;
      end
   end

   assign grp_bits = page_q[int'(grp_sel)*BURST +: BURST];

endmodule

// File: rtl/bank_serializer.sv
module bank_serializer #(
   parameter int BURST     = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             capture,
   input  logic             shift,
   input  logic [BURST-1:0] grp_in,
   output logic             bit_o
);

   logic [BURST-1:0] sh_q;

   if (LSB_FIRST) begin : g_lsb
      always_ff @(posedge clk) begin
         if (rst)          sh_q <= '0;
         else if (capture) sh_q <= grp_in;
         else if (shift)   sh_q <= sh_q >> 1;
      end
      assign bit_o = sh_q[0];
   end else begin : g_msb
      always_ff @(posedge clk) begin
         if (rst)          sh_q <= '0;
         else if (capture) sh_q <= grp_in;
         else if (shift)   sh_q <= sh_q << 1;
      end
      assign bit_o = sh_q[BURST-1];
   end

endmodule

// File: rtl/openrow_bank_ctrl.sv
module openrow_bank_ctrl
   import openrow_bank_pkg::*;
#(
   parameter int ROW_W     = 12,
   parameter int COL_W     = 12,
   parameter int BURST     = 8,
   parameter int L_HIT     = 2,
   parameter int L_EMPTY   = 4,
   parameter int L_CONF    = 6,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic [ROW_W+COL_W-1:0] req_addr,
   output logic                   cmd_ras,
   output logic                   cmd_cas,
   output logic                   cmd_wb,
   output logic [ROW_W-1:0]       cmd_row,
   output logic [COL_W-1:0]       cmd_col,
   output logic                   dout_valid,
   output logic                   dout_bit,
   output logic [1:0]             acc_class
);

   localparam int ADDR_W = ROW_W + COL_W;
   localparam int GRP_W  = $clog2(BURST);
   localparam int SEL_W  = COL_W - GRP_W;
   localparam int CNT_W  = $clog2(L_CONF + BURST + 1);

   // Elaboration-time parameter checks
   if (L_HIT < 2) begin : g_bad_hit
      $error("L_HIT must be at least 2");
   end
   if (L_EMPTY <= L_HIT) begin : g_bad_empty
      $error("L_EMPTY must exceed L_HIT");
   end
   if (L_CONF <= L_EMPTY) begin : g_bad_conf
      $error("L_CONF must exceed L_EMPTY");
   end
   if ((1 << GRP_W) != BURST || GRP_W >= COL_W) begin : g_bad_burst
      $error("BURST must be a power of two narrower than a row");
   end

   logic             busy;
   logic             accept;
   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;
   logic             open_vld;
   logic [ROW_W-1:0] open_row;
   acc_class_e       cls_next;
   acc_class_e       cls_cur;
   logic [CNT_W-1:0] lat_next;
   logic             ras;
   logic             cas;
   logic             wb;
   logic             dvalid;
   logic [BURST-1:0] grp_bits;
   logic             ser_bit;

   assign req_ready = !busy;
   assign accept    = req_valid && !busy;

   always_ff @(posedge clk) begin
      if (rst) begin
         row_q <= '0;
         col_q <= '0;
      end else if (accept) begin
         row_q <= req_addr[ADDR_W-1:COL_W];
         col_q <= req_addr[COL_W-1:0];
      end
   end

   bank_row_classifier #(
      .ROW_W(ROW_W), .CNT_W(CNT_W),
      .L_HIT(L_HIT), .L_EMPTY(L_EMPTY), .L_CONF(L_CONF)
   ) u_class (
      .open_vld (open_vld),
      .open_row (open_row),
      .req_row  (req_addr[ADDR_W-1:COL_W]),
      .cls      (cls_next),
      .lat      (lat_next)
   );

   bank_sequencer #(
      .CNT_W(CNT_W), .BURST(BURST), .L_HIT(L_HIT), .L_EMPTY(L_EMPTY)
   ) u_seq (
      .clk    (clk),
      .rst    (rst),
      .accept (accept),
      .cls_in (cls_next),
      .lat_in (lat_next),
      .busy   (busy),
      .cls    (cls_cur),
      .ras    (ras),
      .cas    (cas),
      .wb     (wb),
      .dvalid (dvalid)
   );

   bank_row_store #(
      .ROW_W(ROW_W), .COL_W(COL_W), .BURST(BURST)
   ) u_store (
      .clk      (clk),
      .rst      (rst),
      .activate (ras),
      .close    (wb),
      .act_row  (row_q),
      .grp_sel  (col_q[COL_W-1:GRP_W]),
      .open_vld (open_vld),
      .open_row (open_row),
      .grp_bits (grp_bits)
   );

   bank_serializer #(
      .BURST(BURST), .LSB_FIRST(LSB_FIRST)
   ) u_ser (
      .clk     (clk),
      .rst     (rst),
      .capture (cas),
      .shift   (dvalid),
      .grp_in  (grp_bits),
      .bit_o   (ser_bit)
   );

   assign cmd_ras    = ras;
   assign cmd_cas    = cas;
   assign cmd_wb     = wb;
   assign cmd_row    = wb ? open_row : (ras ? row_q : '0);
   assign cmd_col    = cas ? col_q : '0;
   assign dout_valid = dvalid;
   assign dout_bit   = dvalid & ser_bit;
   assign acc_class  = dvalid ? cls_cur : ACC_NONE;

   // Select width is fixed by COL_W and BURST together
   localparam int SEL_CHECK = SEL_W;
   if (SEL_CHECK < 1) begin : g_bad_sel
      $error("row must hold more than one group");
   end

endmodule

// File: rtl/openrow_bank_ctrl_chk.sv
module openrow_bank_ctrl_chk #(
   parameter int ROW_W = 12,
   parameter int BURST = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             req_valid,
   input logic             req_ready,
   input logic [ROW_W-1:0] req_row,
   input logic             cmd_ras,
   input logic             cmd_cas,
   input logic             cmd_wb,
   input logic [ROW_W-1:0] cmd_row,
   input logic             dout_valid,
   input logic [1:0]       acc_class
);

   localparam int RUN_W = $clog2(BURST + 1);

   logic             ck_open;
   logic [ROW_W-1:0] ck_row;
   logic [1:0]       pred;
   logic [RUN_W-1:0] run;

   // Open-row state as seen on the command strobes
   always_ff @(posedge clk) begin
      if (rst) begin
         ck_open <= 1'b0;
         ck_row  <= '0;
         pred    <= 2'b00;
         run     <= '0;
      end else begin
         if (cmd_ras) begin
            ck_open <= 1'b1;
            ck_row  <= cmd_row;
         end else if (cmd_wb) begin
            ck_open <= 1'b0;
         end
         if (req_valid && req_ready) begin
            pred <= !ck_open ? 2'b10 : ((req_row == ck_row) ? 2'b01 : 2'b11);
         end
         run <= dout_valid ? run + RUN_W'(1) : '0;
      end
   end

   // R8
   accept_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready) |=> !req_ready);

   // R8
   data_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
      dout_valid |-> !req_ready);

   // R9
   class_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !dout_valid |-> (acc_class == 2'b00));

   // R3
   class_match_chk: assert property (@(posedge clk) disable iff (rst)
      dout_valid |-> (acc_class == pred));

   // R4
   cas_then_data_chk: assert property (@(posedge clk) disable iff (rst)
      cmd_cas |=> dout_valid);

   // R6
   wb_old_row_chk: assert property (@(posedge clk) disable iff (rst)
      cmd_wb |-> (ck_open && cmd_row == ck_row));

   // R2
   one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({cmd_ras, cmd_cas, cmd_wb}));

   // R7
   burst_over_chk: assert property (@(posedge clk) disable iff (rst)
      dout_valid |-> (run < RUN_W'(BURST)));

   // R7
   burst_len_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(dout_valid) |-> (run == RUN_W'(BURST)));

endmodule

bind openrow_bank_ctrl openrow_bank_ctrl_chk #(
   .ROW_W(ROW_W), .BURST(BURST)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_row    (req_addr[ROW_W+COL_W-1:COL_W]),
   .cmd_ras    (cmd_ras),
   .cmd_cas    (cmd_cas),
   .cmd_wb     (cmd_wb),
   .cmd_row    (cmd_row),
   .dout_valid (dout_valid),
   .acc_class  (acc_class)
);

// File: tb/openrow_bank_ctrl_test.sv
`timescale 1ns/1ps
module openrow_bank_ctrl_test;

   localparam int LH = 2;
   localparam int LE = 4;
   localparam int LC = 6;
   localparam int NB = 8;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic [23:0] req_addr = '0;
   logic        req_ready;
   logic        cmd_ras, cmd_cas, cmd_wb;
   logic [11:0] cmd_row, cmd_col;
   logic        dout_valid, dout_bit;
   logic [1:0]  acc_class;

   always #2 clk = ~clk;

   openrow_bank_ctrl uut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .cmd_ras(cmd_ras), .cmd_cas(cmd_cas),
      .cmd_wb(cmd_wb), .cmd_row(cmd_row), .cmd_col(cmd_col),
      .dout_valid(dout_valid), .dout_bit(dout_bit), .acc_class(acc_class)
   );

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   // Reference model state
   bit m_busy = 0, m_open = 0, m_fresh = 1, m_first = 0, just_acc = 0;
   int m_n = 0, m_lat = 0, m_cls = 0, m_row = 0, m_col = 0, m_old = 0, m_orow = 0;

   logic [23:0] q_addr[$];
   int          q_gap[$];

   task automatic chk(input string req, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
      end
   endtask

   task automatic push(input int row, input int col, input int gap);
      q_addr.push_back(24'((row << 12) | col));
      q_gap.push_back(gap);
   endtask

   task automatic idle_check(input string req);
      chk(req, "ready", int'(req_ready), 1);
      chk(req, "ras", int'(cmd_ras), 0);
      chk(req, "cas", int'(cmd_cas), 0);
      chk(req, "wb", int'(cmd_wb), 0);
      chk(req, "dout_valid", int'(dout_valid), 0);
      chk(req, "dout_bit", int'(dout_bit), 0);
      chk(req, "class", int'(acc_class), 0);
   endtask

   task automatic compare();
      bit e_ras, e_cas, e_wb, e_dv;
      int e_row, e_col, e_bit, e_cls, ras_at, data_byte;
      string stag;
      e_wb  = m_busy && m_cls == 3 && m_n == 1;
      ras_at = (m_cls == 2) ? 1 : LC - LE + LH - 1;
      e_ras = m_busy && m_cls != 1 && m_n == ras_at;
      e_cas = m_busy && m_n == m_lat - 1;
      e_dv  = m_busy && m_n >= m_lat;
      e_row = e_wb ? m_old : (e_ras ? m_row : 0);
      e_col = e_cas ? m_col : 0;
      data_byte = (m_row + (m_col >> 3)) & 255;
      e_bit = e_dv ? ((data_byte >> (m_n - m_lat)) & 1) : 0;
      e_cls = e_dv ? m_cls : 0;
      stag = (!m_busy) ? "R2" : (m_cls == 1) ? "R4" : (m_cls == 2) ? "R5" : "R6";
      chk("R8", "ready", int'(req_ready), m_busy ? 0 : 1);
      chk(stag, "ras", int'(cmd_ras), int'(e_ras));
      chk(stag, "cas", int'(cmd_cas), int'(e_cas));
      chk(stag, "wb", int'(cmd_wb), int'(e_wb));
      chk("R2", "cmd_row", int'(cmd_row), e_row);
      chk("R2", "cmd_col", int'(cmd_col), e_col);
      chk("R7", "dout_valid", int'(dout_valid), int'(e_dv));
      chk("R7", "dout_bit", int'(dout_bit), e_bit);
      if (!e_dv)
         chk("R9", "class", int'(acc_class), 0);
      else if (m_first)
         chk("R1", "class after reset", int'(acc_class), e_cls);
      else if (m_cls == 1)
         chk("R10", "class open page", int'(acc_class), e_cls);
      else
         chk("R3", "class", int'(acc_class), e_cls);
   endtask

   task automatic model_step();
      int row;
      if (m_busy) begin
         if (m_n == m_lat + NB - 1) m_busy = 0;
         else m_n++;
      end else if (req_valid) begin
         row = int'(req_addr[23:12]);
         if (!m_open) begin m_cls = 2; m_lat = LE; end
         else if (m_orow == row) begin m_cls = 1; m_lat = LH; end
         else begin m_cls = 3; m_lat = LC; end
         m_old   = m_orow;
         m_row   = row;
         m_col   = int'(req_addr[11:0]);
         m_orow  = row;
         m_open  = 1;
         m_busy  = 1;
         m_n     = 1;
         m_first = m_fresh;
         m_fresh = 0;
         just_acc = 1;
         void'(q_addr.pop_front());
         void'(q_gap.pop_front());
      end
   endtask

   initial begin
      push(5, 12'h010, 0);     // empty after reset, byte 7
      push(5, 12'h7F8, 0);     // hit, held valid while busy
      push(9, 12'h003, 2);     // conflict
      push(9, 12'hFFF, 0);     // hit, last group
      push(12'hFFF, 0, 1);     // conflict
      push(12'hFFF, 8, 0);     // hit, byte wraps to 0
      push(12'hFFF, 8, 3);     // hit after a gap
      push(0, 0, 0);           // conflict
      push(0, 12'h0A0, -1);    // reset first, then empty
      push(12'h123, 12'h456, 0);
      push(12'h123, 12'h457, 5);
      push(12'h124, 12'h456, 0);

      repeat (3) @(negedge clk);
      idle_check("R1");        // state while reset is high
      rst = 1'b0;
      @(negedge clk);
      idle_check("R1");        // first cycle after reset

      forever begin
         @(negedge clk);
         compare();
         if (just_acc) begin
            req_valid = 1'b0;
            just_acc = 0;
         end
         if (!req_valid && q_addr.size() > 0) begin
            if (q_gap[0] < 0) begin
               if (!m_busy) begin
                  rst = 1'b1;
                  repeat (2) @(negedge clk);
                  idle_check("R1");
                  rst = 1'b0;
                  m_open = 0;
                  m_fresh = 1;
                  q_gap[0] = 0;
                  @(negedge clk);
                  idle_check("R1");
                  req_valid = 1'b1;
                  req_addr = q_addr[0];
               end
            end else if (q_gap[0] > 0) begin
               q_gap[0] = q_gap[0] - 1;
            end else begin
               req_valid = 1'b1;
               req_addr = q_addr[0];
            end
         end
         model_step();
         if (q_addr.size() == 0 && !m_busy && !req_valid) break;
      end

      repeat (3) begin
         @(negedge clk);
         compare();
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R8 watchdog expired actual=busy expected=idle");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule